// File: doc/BRIEF.md
# Programmable Interval Timer

A down-counting interval timer with a small synchronous register port. A two-stage prescaler divides the system clock. The first stage always divides by a base factor. A second, slower factor can be switched in by a control bit. Each prescaled tick steps the counter down by one. When a tick arrives while the counter sits at zero, that is terminal count. At terminal count the counter either reloads from the modulus register (periodic operation) or wraps to all ones (free-running operation). In both cases a sticky event flag is set, and that flag drives the interrupt line when interrupts are enabled.

Software disables the timer, writes the modulus, then enables it. Enabling loads the modulus into the counter. A one-shot interval is started differently: set the overwrite bit, then write a new modulus. That write lands in the counter at once. The event flag is cleared by writing a one to its bit, so a read-modify-write of the control word clears it without changing the other controls. The counter register reads back the number of ticks remaining.

Top module: `interval_timer`

## Requirements
- R1: After reset every control bit, the event flag, the modulus and the counter are zero, `irq` is low and every address reads 0.
- R2: While running, the prescaler issues one tick every 2 clocks with the slow-select bit clear, and one tick every 128 clocks with it set. The first tick comes 2 (or 128) clocks after the counter is loaded.
- R3: On each tick with the counter non-zero, the counter decreases by exactly one. The counter register (offset 4) reads the current remaining count.
- R4: With the reload bit set, a tick at zero loads the modulus, so the counter repeats every modulus+1 ticks.
- R5: With the reload bit clear, a tick at zero takes the counter to 0xFFFF and counting continues downward.
- R6: A tick at zero sets the event flag (control bit 2). The flag stays set until software clears it.
- R7: A control write with bit 2 set clears the flag, and one with bit 2 clear leaves it alone. A terminal count in the same cycle as a clearing write leaves the flag set.
- R8: `irq` is high exactly when both the event flag and the interrupt-enable bit (bit 3) are set.
- R9: A control write that turns run (bit 0) from 0 to 1 loads the counter from the modulus and restarts the prescaler. While run is clear, the counter holds and no ticks occur.
- R10: A modulus write with overwrite (bit 4) set loads the written value into the counter in the same cycle and restarts the prescaler. With overwrite clear, only the modulus changes.
- R11: Register map, addressed by `bus_addr` with writes taken on `bus_wr`. Offset 0 is control/status, with bit 0 run, bit 1 reload, bit 2 event flag, bit 3 interrupt enable, bit 4 overwrite and bit 5 slow select; its upper bits read 0. Offset 2 is the write-only modulus, which reads 0. Offset 4 is the read-only counter. Writes to offset 4 or to unmapped offsets change nothing, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, taken on the rising clock edge |
| bus_addr | input | 3 | Byte offset of the register accessed |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request, the event flag gated by interrupt enable |

## Verification
The assertions assume that `bus_addr` and `bus_wdata` are stable whenever `bus_wr` is high. They also assume that a modulus write and a control write never coincide, which the single address port guarantees. The stimulus drives every input half a period away from the rising edge. It issues at most one register access per cycle. It changes modulus and mode while the timer is disabled, except in the overwrite and clear-flag cases, where writing while running is the behaviour under test.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
   localparam int unsigned CTL_RUN  = 0;
   localparam int unsigned CTL_RLD  = 1;
   localparam int unsigned CTL_FLAG = 2;
   localparam int unsigned CTL_IEN  = 3;
   localparam int unsigned CTL_OVW  = 4;
   localparam int unsigned CTL_SLOW = 5;

   localparam logic [2:0] OFS_CTRL = 3'd0;
   localparam logic [2:0] OFS_MOD  = 3'd2;
   localparam logic [2:0] OFS_CNT  = 3'd4;

   typedef struct packed {
      logic slow;
      logic ovw;
      logic ien;
      logic rld;
      logic run;
   } itmr_ctrl_t;
endpackage

// File: rtl/itmr_prescaler.sv
module itmr_prescaler #(
   parameter int unsigned BASE_DIV = 2,
   parameter int unsigned SLOW_DIV = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   input  logic slow_sel,
   output logic tick
);
   localparam int unsigned FULL_DIV = BASE_DIV * SLOW_DIV;
   localparam int unsigned PRE_W    = (FULL_DIV > 2) ? $clog2(FULL_DIV) : 1;
   localparam logic [PRE_W-1:0] FAST_TOP = PRE_W'(BASE_DIV - 1);
   localparam logic [PRE_W-1:0] SLOW_TOP = PRE_W'(FULL_DIV - 1);

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] top_sel;

   generate
      if (SLOW_DIV > 1) begin : g_two_rate
         always_comb top_sel = slow_sel ? SLOW_TOP : FAST_TOP;
      end else begin : g_one_rate
         logic unused_sel;
         always_comb unused_sel = slow_sel;
         always_comb top_sel = FAST_TOP;
      end
   endgenerate

   always_comb tick = run && (pre_q >= top_sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
      end else if (!run || restart || tick) begin
         pre_q <= '0;
      end else begin
         pre_q <= pre_q + 1'b1;
      end
   end

   AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !tick); // R9
   AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick); // R2
endmodule

// File: rtl/itmr_counter.sv
module itmr_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             reload_en,
   input  logic [CNT_W-1:0] mod_val,
   output logic [CNT_W-1:0] cnt,
   output logic             term
);
   localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;
   logic             at_zero;

   always_comb at_zero = (cnt_q == '0);
   always_comb term    = tick && at_zero;
   always_comb cnt     = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (tick) begin
         if (at_zero) begin
            cnt_q <= reload_en ? mod_val : ALL_ONES;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      tick && !load && (cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1); // R3
   AST_RELOAD_MOD: assert property (@(posedge clk) disable iff (!rst_n)
      tick && !load && (cnt_q == '0) && reload_en |=> cnt_q == $past(mod_val)); // R4
   AST_WRAP_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      tick && !load && (cnt_q == '0) && !reload_en |=> cnt_q == ALL_ONES); // R5
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !tick && !load |=> $stable(cnt_q)); // R9
   AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> cnt_q == $past(load_val)); // R10
endmodule

// File: rtl/itmr_regs.sv
module itmr_regs
   import itmr_pkg::*;
#(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [CNT_W-1:0]  bus_wdata,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              term,
   output logic [CNT_W-1:0]  bus_rdata,
   output itmr_ctrl_t        ctrl,
   output logic [CNT_W-1:0]  mod_val,
   output logic              load,
   output logic [CNT_W-1:0]  load_val,
   output logic              flag
);
   itmr_ctrl_t       ctrl_q;
   logic [CNT_W-1:0] mod_q;
   logic             flag_q;
   logic             wr_ctrl;
   logic             wr_mod;
   logic             run_rise;
   logic             ovw_load;
   logic             clr_req;

   always_comb begin
      wr_ctrl  = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
      wr_mod   = bus_wr && (bus_addr == ADDR_W'(OFS_MOD));
      run_rise = wr_ctrl && !ctrl_q.run && bus_wdata[CTL_RUN];
      ovw_load = wr_mod && ctrl_q.ovw;
      clr_req  = wr_ctrl && bus_wdata[CTL_FLAG];
      load     = run_rise || ovw_load;
      load_val = wr_mod ? bus_wdata : mod_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_ctrl) begin
         ctrl_q.run  <= bus_wdata[CTL_RUN];
         ctrl_q.rld  <= bus_wdata[CTL_RLD];
         ctrl_q.ien  <= bus_wdata[CTL_IEN];
         ctrl_q.ovw  <= bus_wdata[CTL_OVW];
         ctrl_q.slow <= bus_wdata[CTL_SLOW];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mod_q <= '0;
      end else if (wr_mod) begin
         mod_q <= bus_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (term) begin
         flag_q <= 1'b1;
      end else if (clr_req) begin
         flag_q <= 1'b0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         ADDR_W'(OFS_CTRL): begin
            bus_rdata[CTL_RUN]  = ctrl_q.run;
            bus_rdata[CTL_RLD]  = ctrl_q.rld;
            bus_rdata[CTL_FLAG] = flag_q;
            bus_rdata[CTL_IEN]  = ctrl_q.ien;
            bus_rdata[CTL_OVW]  = ctrl_q.ovw;
            bus_rdata[CTL_SLOW] = ctrl_q.slow;
         end
         ADDR_W'(OFS_CNT): bus_rdata = cnt;
         default: bus_rdata = '0;
      endcase
   end

   always_comb begin
      ctrl    = ctrl_q;
      mod_val = mod_q;
      flag    = flag_q;
   end

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      flag_q && !clr_req |=> flag_q); // R6
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      term |=> flag_q); // R7
   AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      clr_req && !term |=> !flag_q); // R7
   AST_MOD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_mod |=> $stable(mod_q)); // R11
endmodule

// File: rtl/interval_timer.sv
module interval_timer
   import itmr_pkg::*;
#(
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned ADDR_W   = 3,
   parameter int unsigned BASE_DIV = 2,
   parameter int unsigned SLOW_DIV = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [CNT_W-1:0]  bus_wdata,
   output logic [CNT_W-1:0]  bus_rdata,
   output logic              irq
);
   generate
      if (CNT_W < 6) begin : g_bad_width
         $error("interval_timer: CNT_W must cover all control bits");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("interval_timer: ADDR_W must reach offset 4");
      end
      if (BASE_DIV < 2) begin : g_bad_base
         $error("interval_timer: BASE_DIV must be at least 2");
      end
      if (SLOW_DIV < 1) begin : g_bad_slow
         $error("interval_timer: SLOW_DIV must be at least 1");
      end
   endgenerate

   itmr_ctrl_t       ctrl;
   logic [CNT_W-1:0] mod_val;
   logic [CNT_W-1:0] load_val;
   logic [CNT_W-1:0] cnt;
   logic             load;
   logic             tick;
   logic             term;
   logic             flag;

   itmr_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .cnt       (cnt),
      .term      (term),
      .bus_rdata (bus_rdata),
      .ctrl      (ctrl),
      .mod_val   (mod_val),
      .load      (load),
      .load_val  (load_val),
      .flag      (flag)
   );

   itmr_prescaler #(.BASE_DIV(BASE_DIV), .SLOW_DIV(SLOW_DIV)) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (ctrl.run),
      .restart  (load),
      .slow_sel (ctrl.slow),
      .tick     (tick)
   );

   itmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .load      (load),
      .load_val  (load_val),
      .reload_en (ctrl.rld),
      .mod_val   (mod_val),
      .cnt       (cnt),
      .term      (term)
   );

   always_comb irq = flag && ctrl.ien;

   AST_IRQ_NEEDS_IEN: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl.ien |-> !irq); // R8
   AST_TERM_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      term |-> (cnt == '0) && ctrl.run); // R6
endmodule

// File: tb/interval_timer_tb.sv
`timescale 1ns/1ps
module interval_timer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = 3'd4;
   logic [15:0] bus_wdata = 16'h0;
   logic [15:0] bus_rdata;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;
   int cycles = 0;
   string tag = "R1";
   logic [2:0] idle_addr = 3'd4;

   // reference state
   int m_run = 0, m_rld = 0, m_ien = 0, m_ovw = 0, m_slow = 0, m_flag = 0;
   int m_pre = 0, m_cnt = 0, m_mod = 0;

   always #2 clk = ~clk;

   interval_timer u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int exp_read(input logic [2:0] a);
      case (a)
         3'd0: return m_run | (m_rld << 1) | (m_flag << 2) | (m_ien << 3) |
                      (m_ovw << 4) | (m_slow << 5);
         3'd4: return m_cnt;
         default: return 0;
      endcase
   endfunction

   // behavioural reference, updated on each rising edge
   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         m_run = 0; m_rld = 0; m_ien = 0; m_ovw = 0; m_slow = 0; m_flag = 0;
         m_pre = 0; m_cnt = 0; m_mod = 0;
      end else begin
         int div, n_pre, n_cnt, n_flag, n_mod;
         bit tk, wc, wm;
         div = m_slow ? 128 : 2;
         tk = (m_run != 0) && (m_pre >= div - 1);
         wc = bus_wr && bus_addr == 3'd0;
         wm = bus_wr && bus_addr == 3'd2;
         n_pre = (m_run == 0 || tk) ? 0 : m_pre + 1;
         n_cnt = m_cnt;
         if (tk) n_cnt = (m_cnt == 0) ? (m_rld != 0 ? m_mod : 'hFFFF) : m_cnt - 1;
         n_flag = m_flag;
         if (wc && bus_wdata[2]) n_flag = 0;
         if (tk && m_cnt == 0) n_flag = 1;
         n_mod = m_mod;
         if (wm) begin
            n_mod = bus_wdata;
            if (m_ovw != 0) begin n_cnt = bus_wdata; n_pre = 0; end
         end
         if (wc) begin
            if (m_run == 0 && bus_wdata[0]) begin n_cnt = m_mod; n_pre = 0; end
            m_run = bus_wdata[0]; m_rld = bus_wdata[1]; m_ien = bus_wdata[3];
            m_ovw = bus_wdata[4]; m_slow = bus_wdata[5];
         end
         m_pre = n_pre; m_cnt = n_cnt; m_flag = n_flag; m_mod = n_mod;
      end
   end

   // every-cycle comparison, a quarter period after the falling edge
   always @(negedge clk) begin
      #1;
      chk({tag, " rdata"}, int'(bus_rdata), exp_read(bus_addr));
      chk("R8 irq", int'(irq), (m_flag != 0 && m_ien != 0) ? 1 : 0);
   end

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = idle_addr;
   endtask

   task automatic rd(input logic [2:0] a, output int v);
      bus_addr = a;
      #0.5;
      v = int'(bus_rdata);
      bus_addr = idle_addr;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      int v, first;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd(3'd0, v); chk("R1 ctrl", v, 0);
      rd(3'd4, v); chk("R1 cnt", v, 0);
      chk("R1 irq", int'(irq), 0);

      // R11 map: writes to counter/unmapped ignored, modulus reads 0
      tag = "R11";
      wr(3'd4, 16'h1234);
      wr(3'd6, 16'hFFFF);
      rd(3'd4, v); chk("R11 cnt write ignored", v, 0);
      wr(3'd2, 16'h0005);
      rd(3'd2, v); chk("R11 mod reads zero", v, 0);
      rd(3'd6, v); chk("R11 unmapped reads zero", v, 0);

      // R9 enable loads modulus; R4 periodic with R2 fast rate
      tag = "R9";
      wr(3'd0, 16'h000B);
      rd(3'd4, v); chk("R9 load on enable", v, 5);
      @(posedge clk); @(negedge clk);
      rd(3'd4, v); chk("R2 no tick after 1 clk", v, 5);
      @(posedge clk); @(negedge clk);
      rd(3'd4, v); chk("R3 step after 2 clks", v, 4);
      tag = "R4";
      idle(8);
      rd(3'd4, v); chk("R4 reached zero", v, 0);
      idle(2);
      rd(3'd4, v); chk("R4 reload to modulus", v, 5);
      rd(3'd0, v); chk("R6 flag set", (v >> 2) & 1, 1);
      chk("R8 irq high", int'(irq), 1);
      tag = "R6";
      idle(30);

      // R7 write-one-to-clear and write-zero keeps
      tag = "R7";
      wr(3'd0, 16'h000B);
      rd(3'd0, v); chk("R7 zero write keeps flag", (v >> 2) & 1, 1);
      idle(5);
      wr(3'd0, 16'h000F);
      rd(3'd0, v); chk("R7 one write clears", (v >> 2) & 1, 0);
      wr(3'd0, 16'h0003);
      tag = "R8";
      idle(20);
      chk("R8 irq masked", int'(irq), 0);

      // R9 disable holds
      tag = "R9";
      wr(3'd0, 16'h0004);
      rd(3'd4, first);
      idle(20);
      rd(3'd4, v); chk("R9 hold while stopped", v, first);

      // R5 wrap
      tag = "R5";
      wr(3'd2, 16'h0002);
      wr(3'd0, 16'h0009);
      repeat (6) @(posedge clk);
      @(negedge clk);
      rd(3'd4, v); chk("R5 wrap to all ones", v, 'hFFFF);
      rd(3'd0, v); chk("R6 flag on wrap", (v >> 2) & 1, 1);
      idle(10);

      // R10 overwrite
      tag = "R10";
      wr(3'd0, 16'h0004);
      wr(3'd0, 16'h0011);
      wr(3'd2, 16'h0010);
      rd(3'd4, v); chk("R10 immediate load", v, 16);
      idle(7);
      wr(3'd0, 16'h0001);
      wr(3'd2, 16'h0020);
      rd(3'd4, v); chk("R10 no load without overwrite", (v == 32) ? 1 : 0, 0);
      idle(10);

      // R7 set wins: modulus 0 reload, clears hammered while terminal counts occur
      tag = "R7";
      wr(3'd0, 16'h0004);
      wr(3'd2, 16'h0000);
      wr(3'd0, 16'h000B);
      for (int i = 0; i < 12; i++) wr(3'd0, 16'h000F);
      idle(6);

      // R2 slow prescaler
      tag = "R2";
      wr(3'd0, 16'h0004);
      wr(3'd2, 16'h0003);
      wr(3'd0, 16'h002B);
      repeat (127) @(posedge clk);
      @(negedge clk);
      rd(3'd4, v); chk("R2 slow no tick yet", v, 3);
      @(posedge clk); @(negedge clk);
      rd(3'd4, v); chk("R2 slow tick at 128", v, 2);
      idle(1100);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      wait (cycles > 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule